// File: doc/BRIEF.md
# Flash Line Prefetch Read Controller

This block sits between a processor's instruction-fetch port and a slow flash array that returns 128-bit lines. One line holds four 32-bit or eight 16-bit instructions. The controller keeps the line in use as the current line. When prefetch is switched on, it also reads the next sequential line into a second buffer while the processor is still fetching from the current one. A request that falls in either buffer is answered in the same cycle. A request that falls in neither one stalls the fetch port while the controller reads the target line.

Each flash access holds the line address for N+1 clock cycles, where N is the wait-state count in a latency register. Software writes that register. A new value only takes effect when no flash access is in progress, and the read-back always shows the count that is actually in use. A branch to a line outside both buffers abandons any prefetch in progress and starts the demand read in the same cycle.

The fetch port uses valid/ready. The requester raises `req_valid` with `req_addr` and `req_half`, and must hold all three unchanged while `req_ready` is low. The transfer completes in the cycle where both are high, and `rsp_data` is valid in that same cycle. The flash side is a plain address/strobe port with no back-pressure.

Top module: `fpc_prefetch_ctrl`

## Requirements
- R1: After reset the latency read-back is 0 and both line buffers are empty, so the first request sees `req_ready` low.
- R2: A flash access keeps `fl_rd` high and `fl_line` unchanged for N+1 consecutive cycles, and the line is taken from `fl_rdata` in the last of them; only a branch miss may replace the address earlier.
- R3: A request that misses both buffers, while its line is not already being read, keeps `req_ready` low for exactly N+1 cycles.
- R4: A request that hits a buffered line is accepted in the same cycle. Line matching uses address bits [31:4] only. In 32-bit mode (`req_half`=0), `rsp_data` is the word at bit offset 32*addr[3:2] within the line.
- R5: In 16-bit mode (`req_half`=1), `rsp_data[15:0]` is the halfword at bit offset 16*addr[3:1] and `rsp_data[31:16]` is zero.
- R6: With prefetch enabled, the line after the current one is read without any request, and a later request to that line is accepted with no stall.
- R7: A request to the prefetched line makes it the current line and starts the next sequential prefetch. With N=2 and prefetch enabled, a back-to-back 32-bit sequential stream therefore runs without stalls after its first line.
- R8: With prefetch disabled, no flash read starts unless a request misses. A sequential step into the next line then costs N+1 stall cycles.
- R9: A branch miss while a prefetch is in progress abandons the prefetch and starts the demand read in that same cycle, so the stall is N+1. The abandoned line is never delivered.
- R10: A latency write made while a flash access is in progress does not change the read-back or the timing of that access. The new value appears once the controller is idle.
- R11: A request to the line that a prefetch is currently reading waits for that read to finish instead of restarting it, and is accepted in the cycle after the line arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_lat_we | input | 1 | Write strobe for the wait-state count |
| cfg_lat_wdata | input | 4 | Wait-state count to write |
| cfg_lat_rdata | output | 4 | Wait-state count currently in use |
| cfg_pf_en | input | 1 | Enable for sequential line prefetch |
| req_valid | input | 1 | Fetch request valid |
| req_addr | input | 32 | Fetch byte address |
| req_half | input | 1 | 1: 16-bit fetch, 0: 32-bit fetch |
| req_ready | output | 1 | Request accepted this cycle |
| rsp_data | output | 32 | Fetched instruction, valid when `req_valid` and `req_ready` are both high |
| fl_rd | output | 1 | Flash access in progress |
| fl_line | output | 28 | Line address presented to flash |
| fl_rdata | input | 128 | Line data returned by flash |

## Verification
The interesting collision is a branch miss arriving in a cycle where a prefetch read is still in progress. In that cycle the demand launch must take the flash port from the prefetch. The bench provokes it by following a demand miss directly with a far branch, and then with a request to the abandoned line. It judges both by the exact stall count and by the returned data. The flash model returns corrupted data for any line address that was not held for the full wait-state count, so a capture taken before the access finished, or data coming from the abandoned read, shows up as a data mismatch. A second collision is a latency write landing in the same cycle as a demand launch: the bench reads the register back during the access and after it.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  typedef enum logic {FETCH_W32 = 1'b0, FETCH_H16 = 1'b1} fetch_mode_e;
endpackage

// File: rtl/fpc_lat_reg.sv
module fpc_lat_reg #(
  parameter int LAT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [LAT_W-1:0] wdata,
  input  logic             active,
  output logic [LAT_W-1:0] lat
);
  logic [LAT_W-1:0] pend_q;
  logic             pend_v;

  // A write is parked while a flash access is running and handed over at idle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat    <= '0;
      pend_q <= '0;
      pend_v <= 1'b0;
    end else if (we && !active) begin
      lat    <= wdata;
      pend_v <= 1'b0;
    end else if (we) begin
      pend_q <= wdata;
      pend_v <= 1'b1;
    end else if (pend_v && !active) begin
      lat    <= pend_q;
      pend_v <= 1'b0;
    end
  end
endmodule

// File: rtl/fpc_read_engine.sv
module fpc_read_engine #(
  parameter int LINE_AW = 28,
  parameter int LAT_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LAT_W-1:0]   lat,
  input  logic               dmd_go,
  input  logic [LINE_AW-1:0] dmd_line,
  input  logic               pf_go,
  input  logic [LINE_AW-1:0] pf_line,
  output logic               fl_rd,
  output logic [LINE_AW-1:0] fl_line,
  output logic               done,
  output logic               done_dmd,
  output logic               busy,
  output logic [LINE_AW-1:0] busy_line,
  output logic               active
);
  logic               busy_q;
  logic [LAT_W-1:0]   cnt_q;
  logic [LINE_AW-1:0] line_q;
  logic               dem_q;
  logic               start;
  logic [LINE_AW-1:0] start_line;

  assign start      = dmd_go || pf_go;
  assign start_line = dmd_go ? dmd_line : pf_line;
  assign fl_rd      = busy_q || start;
  assign fl_line    = start ? start_line : line_q;
  assign done       = start ? (lat == '0) : (busy_q && cnt_q == '0);
  assign done_dmd   = start ? dmd_go : dem_q;
  assign busy       = busy_q;
  assign busy_line  = line_q;
  assign active     = fl_rd;

  // A demand launch overrides whatever access is in progress.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      line_q <= '0;
      dem_q  <= 1'b0;
    end else if (start) begin
      busy_q <= (lat != '0);
      cnt_q  <= lat - 1'b1;
      line_q <= start_line;
      dem_q  <= dmd_go;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/fpc_word_sel.sv
module fpc_word_sel
  import fpc_pkg::*;
#(
  parameter int LINE_W = 128,
  parameter int WORD_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic [LINE_W-1:0] line,
  input  logic [IDX_W-1:0]  hidx,
  input  fetch_mode_e       mode,
  output logic [WORD_W-1:0] data
);
  localparam int HALF_W = WORD_W / 2;
  localparam int N_WORD = LINE_W / WORD_W;
  localparam int N_HALF = LINE_W / HALF_W;

  logic [WORD_W-1:0] words [N_WORD];
  logic [HALF_W-1:0] halves[N_HALF];

  for (genvar w = 0; w < N_WORD; w++) begin : g_word
    assign words[w] = line[w*WORD_W +: WORD_W];
  end
  for (genvar h = 0; h < N_HALF; h++) begin : g_half
    assign halves[h] = line[h*HALF_W +: HALF_W];
  end

  always_comb begin
    if (mode == FETCH_H16) data = {{HALF_W{1'b0}}, halves[hidx]};
    else                   data = words[hidx[IDX_W-1:1]];
  end
endmodule

// File: rtl/fpc_prefetch_ctrl.sv
module fpc_prefetch_ctrl
  import fpc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 128,
  parameter int WORD_W = 32,
  parameter int LAT_W  = 4,
  localparam int OFS_W   = $clog2(LINE_W / 8),
  localparam int LINE_AW = ADDR_W - OFS_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_lat_we,
  input  logic [LAT_W-1:0]   cfg_lat_wdata,
  output logic [LAT_W-1:0]   cfg_lat_rdata,
  input  logic               cfg_pf_en,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic               req_half,
  output logic               req_ready,
  output logic [WORD_W-1:0]  rsp_data,
  output logic               fl_rd,
  output logic [LINE_AW-1:0] fl_line,
  input  logic [LINE_W-1:0]  fl_rdata
);
  logic [LINE_AW-1:0] req_line;
  logic [LINE_W-1:0]  cur_q, pf_q;
  logic [LINE_AW-1:0] cur_line_q, pf_line_q;
  logic               cur_v, pf_v;
  logic               hit_cur, hit_pf, wait_fl, dmd_go, pf_go;
  logic               eng_done, eng_done_dmd, eng_busy, eng_active;
  logic [LINE_AW-1:0] eng_line;
  fetch_mode_e        mode;

  assign req_line  = req_addr[ADDR_W-1:OFS_W];
  assign hit_cur   = cur_v && (cur_line_q == req_line);
  assign hit_pf    = pf_v && (pf_line_q == req_line) && !hit_cur;
  assign wait_fl   = eng_busy && (eng_line == req_line);
  assign req_ready = hit_cur || hit_pf;
  assign dmd_go    = req_valid && !req_ready && !wait_fl;
  assign pf_go     = cfg_pf_en && cur_v && !pf_v && !eng_busy && !dmd_go;
  assign mode      = req_half ? FETCH_H16 : FETCH_W32;

  fpc_lat_reg #(.LAT_W(LAT_W)) u_lat (
    .clk(clk), .rst_n(rst_n), .we(cfg_lat_we), .wdata(cfg_lat_wdata),
    .active(eng_active), .lat(cfg_lat_rdata)
  );

  fpc_read_engine #(.LINE_AW(LINE_AW), .LAT_W(LAT_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .lat(cfg_lat_rdata),
    .dmd_go(dmd_go), .dmd_line(req_line),
    .pf_go(pf_go), .pf_line(cur_line_q + 1'b1),
    .fl_rd(fl_rd), .fl_line(fl_line), .done(eng_done), .done_dmd(eng_done_dmd),
    .busy(eng_busy), .busy_line(eng_line), .active(eng_active)
  );

  fpc_word_sel #(.LINE_W(LINE_W), .WORD_W(WORD_W), .IDX_W(OFS_W-1)) u_sel (
    .line(hit_cur ? cur_q : pf_q), .hidx(req_addr[OFS_W-1:1]),
    .mode(mode), .data(rsp_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q      <= '0;
      pf_q       <= '0;
      cur_line_q <= '0;
      pf_line_q  <= '0;
      cur_v      <= 1'b0;
      pf_v       <= 1'b0;
    end else begin
      if (dmd_go) pf_v <= 1'b0;
      if (eng_done && eng_done_dmd) begin
        cur_q      <= fl_rdata;
        cur_line_q <= fl_line;
        cur_v      <= 1'b1;
      end else if (eng_done) begin
        pf_q      <= fl_rdata;
        pf_line_q <= fl_line;
        pf_v      <= 1'b1;
      end
      if (req_valid && hit_pf) begin
        cur_q      <= pf_q;
        cur_line_q <= pf_line_q;
        cur_v      <= 1'b1;
        pf_v       <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fpc_prefetch_chk.sv
module fpc_prefetch_chk #(
  parameter int LAT_W   = 4,
  parameter int LINE_AW = 28
) (
  input logic               clk,
  input logic               rst_n,
  input logic [LAT_W-1:0]   cfg_lat_rdata,
  input logic               cfg_pf_en,
  input logic               req_valid,
  input logic [LINE_AW-1:0] req_line,
  input logic               req_ready,
  input logic               fl_rd,
  input logic [LINE_AW-1:0] fl_line,
  input logic               eng_active,
  input logic               eng_done,
  input logic               dmd_go
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (cfg_lat_rdata == '0 && !req_ready));

  // R2
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_rd && !eng_done) |=> (fl_rd && (dmd_go || $stable(fl_line))));

  // R10
  lat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_active |=> $stable(cfg_lat_rdata));

  // R8
  pf_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_pf_en && !req_valid && !fl_rd) |=> (!fl_rd || req_valid || cfg_pf_en));

  // R4
  rehit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!(req_valid && req_line == $past(req_line)) || req_ready));
endmodule

bind fpc_prefetch_ctrl fpc_prefetch_chk #(.LAT_W(LAT_W), .LINE_AW(LINE_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_lat_rdata(cfg_lat_rdata), .cfg_pf_en(cfg_pf_en),
  .req_valid(req_valid), .req_line(req_line), .req_ready(req_ready),
  .fl_rd(fl_rd), .fl_line(fl_line), .eng_active(eng_active),
  .eng_done(eng_done), .dmd_go(dmd_go)
);

// File: tb/fpc_prefetch_ctrl_bench.sv
module fpc_prefetch_ctrl_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_lat_we = 1'b0;
  logic [3:0]   cfg_lat_wdata = '0;
  logic [3:0]   cfg_lat_rdata;
  logic         cfg_pf_en = 1'b0;
  logic         req_valid = 1'b0;
  logic [31:0]  req_addr = '0;
  logic         req_half = 1'b0;
  logic         req_ready;
  logic [31:0]  rsp_data;
  logic         fl_rd;
  logic [27:0]  fl_line;
  logic [127:0] fl_rdata;

  int checks = 0;
  int errors = 0;
  int fl_ws  = 0;

  always #5 clk = ~clk;

  fpc_prefetch_ctrl u_fpc_prefetch_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_lat_we(cfg_lat_we), .cfg_lat_wdata(cfg_lat_wdata),
    .cfg_lat_rdata(cfg_lat_rdata), .cfg_pf_en(cfg_pf_en), .req_valid(req_valid),
    .req_addr(req_addr), .req_half(req_half), .req_ready(req_ready), .rsp_data(rsp_data),
    .fl_rd(fl_rd), .fl_line(fl_line), .fl_rdata(fl_rdata)
  );

  function automatic logic [127:0] line_of(input logic [27:0] ln);
    logic [127:0] r;
    for (int k = 0; k < 4; k++)
      r[k*32 +: 32] = ({4'b0, ln} * 32'd4 + 32'(k) + 32'd1) * 32'h9E37_79B9;
    return r;
  endfunction

  function automatic logic [31:0] exp_data(input logic [31:0] a, input logic h);
    logic [127:0] l;
    l = line_of(a[31:4]);
    if (h) return {16'h0, l[a[3:1]*16 +: 16]};
    return l[a[3:2]*32 +: 32];
  endfunction

  // Flash model: correct data only once the address has been held fl_ws cycles.
  logic [27:0] prv_line = '0;
  logic        prv_rd = 1'b0;
  int          held = 0;
  always @(posedge clk) begin
    if (fl_rd) held <= (prv_rd && prv_line == fl_line) ? held + 1 : 1;
    else       held <= 0;
    prv_rd   <= fl_rd;
    prv_line <= fl_line;
  end
  always_comb begin
    int h;
    h = (fl_rd && prv_rd && prv_line == fl_line) ? held : 0;
    fl_rdata = (h >= fl_ws) ? line_of(fl_line) : ~line_of(fl_line);
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_req(input logic [31:0] a, input logic h, output int st, output logic [31:0] d);
    st = 0;
    @(posedge clk); #1;
    req_valid = 1'b1; req_addr = a; req_half = h;
    forever begin
      #3;
      if (req_ready) begin d = rsp_data; break; end
      st++;
      if (st > 40) begin d = '0; break; end
      @(posedge clk); #1;
    end
  endtask

  task automatic idle(input int n);
    @(posedge clk); #1; req_valid = 1'b0;
    repeat (n - 1) @(posedge clk);
  endtask

  task automatic wr_lat(input logic [3:0] v);
    idle(6);
    @(posedge clk); #1; cfg_lat_we = 1'b1; cfg_lat_wdata = v;
    @(posedge clk); #1; cfg_lat_we = 1'b0;
    @(posedge clk); #4;
    chk(cfg_lat_rdata == v, "R10 read-back after idle write", cfg_lat_rdata, v);
    fl_ws = v;
  endtask

  task automatic req_chk(input logic [31:0] a, input logic h, input int exp_st, input string tag);
    int st; logic [31:0] d;
    do_req(a, h, st, d);
    chk(st == exp_st, {tag, " stall"}, st, exp_st);
    chk(d == exp_data(a, h), {tag, " data"}, d, exp_data(a, h));
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int st; logic [31:0] d; logic [31:0] a; logic h;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #3;
    // R1: reset state
    chk(cfg_lat_rdata == 4'd0, "R1 latency after reset", cfg_lat_rdata, 0);
    chk(req_ready == 1'b0, "R1 no line buffered", req_ready, 0);
    req_chk(32'h0000_0040, 1'b0, 1, "R1/R3 first miss N=0");

    // N=3, prefetch off: R3 R4 R5 R8 R2
    wr_lat(4'd3);
    req_chk(32'h0000_0108, 1'b0, 4, "R3 demand miss N=3 (R2 capture)");
    req_chk(32'h0000_010C, 1'b0, 0, "R4 hit word 3");
    req_chk(32'h0000_0100, 1'b0, 0, "R4 hit word 0");
    req_chk(32'h0000_0106, 1'b1, 0, "R5 halfword 3");
    req_chk(32'h0000_010E, 1'b1, 0, "R5 halfword 7");
    req_chk(32'h0000_0110, 1'b0, 4, "R8 next line without prefetch");
    idle(3); #3;
    chk(fl_rd == 1'b0, "R8 no read while idle", fl_rd, 0);

    // Prefetch on, N=3
    cfg_pf_en = 1'b1;
    req_chk(32'h0000_0400, 1'b0, 4, "R3 miss before branch");
    req_chk(32'h0000_0800, 1'b0, 4, "R9 branch during prefetch");
    req_chk(32'h0000_0410, 1'b0, 4, "R9 abandoned line misses");
    idle(8);
    req_chk(32'h0000_0500, 1'b0, 4, "R3 miss before in-flight wait");
    req_chk(32'h0000_0510, 1'b0, 3, "R11 wait for in-flight line");

    // R10: latency write in the cycle a demand read launches
    cfg_pf_en = 1'b0;
    idle(8);
    @(posedge clk); #1;
    req_valid = 1'b1; req_addr = 32'h0000_0600; req_half = 1'b0;
    cfg_lat_we = 1'b1; cfg_lat_wdata = 4'd1;
    @(posedge clk); #1; cfg_lat_we = 1'b0;
    #3;
    chk(cfg_lat_rdata == 4'd3, "R10 old latency kept during access", cfg_lat_rdata, 3);
    st = 1;
    forever begin
      if (req_ready || st > 40) break;
      st++;
      @(posedge clk); #4;
    end
    chk(st == 4, "R10 access keeps old timing", st, 4);
    chk(rsp_data == exp_data(32'h600, 1'b0), "R10 data", rsp_data, exp_data(32'h600, 1'b0));
    idle(3); #3;
    chk(cfg_lat_rdata == 4'd1, "R10 new latency after idle", cfg_lat_rdata, 1);
    fl_ws = 1;
    req_chk(32'h0000_0704, 1'b0, 2, "R3 demand miss N=1");

    // N=2 with prefetch: R6, R7
    wr_lat(4'd2);
    cfg_pf_en = 1'b1;
    req_chk(32'h0000_0300, 1'b0, 3, "R3 demand miss N=2");
    idle(5);
    req_chk(32'h0000_0310, 1'b0, 0, "R6 prefetched line");
    for (int i = 1; i < 16; i++)
      req_chk(32'h0000_0310 + 32'(i) * 4, 1'b0, 0, "R7 sequential stream");

    // Random mix at N=2
    a = 32'h0000_2000;
    for (int i = 0; i < 400; i++) begin
      if (i % 80 == 0) cfg_pf_en = ~cfg_pf_en;
      h = 1'($urandom % 2);
      if (($urandom % 10) < 6) a = a + (h ? 32'd2 : 32'd4);
      else a = $urandom % 32'h1_0000;
      a = h ? (a & ~32'h1) : (a & ~32'h3);
      do_req(a, h, st, d);
      chk(st <= 4, "R3 random stall bound", st, 4);
      chk(d == exp_data(a, h), "R4 random data", d, exp_data(a, h));
    end
    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule